// File: doc/BRIEF.md
# Keyhole Bus Master Bridge

This block lets several software agents share one narrow management bus. Each agent owns a keyhole: a set of four 32-bit words made of a control/status word, a write-data word, a mutex word and a read-data word. Software first loads the write data, then writes the control word with the start bit set. That launches a single read or write transaction on a target port that uses a request/acknowledge handshake.

A round-robin arbiter serves the pending keyholes one at a time. The target port holds its request until the target acknowledges or a programmable timeout expires. Each keyhole then reports the outcome through a busy flag and two sticky error flags. The mutex word gives agents a cheap claim: a read returns the current claim state and takes the claim at the same time.

Register access is a single-cycle word port. Read data comes back combinationally in the cycle of the read.

Top module: `kh_bus_bridge`

## Requirements
- R1: The CPU word address selects a register. Word 0 is the timeout limit, which resets to 64. Keyhole k owns words 4(k+1) to 4(k+1)+3: control, write data, mutex and read data, in that order. After reset every control word reads 0 and no target request is raised.
- R2: A control write with bit 31 set launches one target transaction. The transaction carries these fields: direction from bit 24 (1 is a write), device index from bits 23:20, register address from bits 15:0, and the keyhole's write-data word.
- R3: Control bit 28 (busy) reads 1 from the start write until the transaction ends. While the request is held, its fields stay stable.
- R4: When a read is acknowledged, the target read data is stored in that keyhole's read-data word. A write leaves that word unchanged.
- R5: While a keyhole is busy, writes to its control and write-data words are ignored. A repeated start causes no further transaction.
- R6: Control bit 29 latches the error input sampled with the acknowledge. It stays set until the next start.
- R7: With a nonzero limit L, a request that is not acknowledged ends after exactly L cycles. Bit 30 is then set and busy clears. An acknowledge in the L-th cycle completes the transaction normally.
- R8: Pending keyholes are served one transaction at a time in round-robin order, starting after the last keyhole served. At least one idle cycle separates two requests.
- R9: A start clears both error flags of that keyhole at once.
- R10: A mutex read returns 0 if the mutex was free and 1 if it was held, and it leaves the mutex held. Writing 0 frees it. Each keyhole has its own mutex.
- R11: A limit of 0 disables the timeout, so a transaction waits for its acknowledge however long it takes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cpu_wr | input | 1 | Register write strobe |
| cpu_rd | input | 1 | Register read strobe (affects only the mutex words) |
| cpu_addr | input | AW | Register word address |
| cpu_wdata | input | 32 | Register write data |
| cpu_rdata | output | 32 | Register read data, combinational |
| tgt_req | output | 1 | Target request, held until the transaction ends |
| tgt_we | output | 1 | Target direction, 1 is a write |
| tgt_dev | output | 4 | Target device index |
| tgt_addr | output | 16 | Target register address |
| tgt_wdata | output | 32 | Target write data |
| tgt_ack | input | 1 | Target acknowledge |
| tgt_err | input | 1 | Target error, valid with the acknowledge |
| tgt_rdata | input | 32 | Target read data, valid with the acknowledge |

## Verification
A corrupted grant pointer or a stale busy bit first shows as a transaction on the target port in the wrong order or with the wrong fields. The scoreboard catches this on the acknowledge cycle of the transaction concerned. A timer that is off by one changes the length of a request that is never answered, so the bench counts every request cycle and compares the count with the limit. An error flag that is lost or not cleared reads back wrong on the first control-word poll after the transaction ends, or straight after the next start.

// File: rtl/kh_bus_bridge.sv
module kh_bus_bridge #(
  parameter int NKH = 4,
  parameter int TMO_W = 16,
  parameter logic [TMO_W-1:0] TMO_RST = 64,
  parameter int AW = $clog2(4*(NKH+1))
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cpu_wr,
  input  logic          cpu_rd,
  input  logic [AW-1:0] cpu_addr,
  input  logic [31:0]   cpu_wdata,
  output logic [31:0]   cpu_rdata,
  output logic          tgt_req,
  output logic          tgt_we,
  output logic [3:0]    tgt_dev,
  output logic [15:0]   tgt_addr,
  output logic [31:0]   tgt_wdata,
  input  logic          tgt_ack,
  input  logic          tgt_err,
  input  logic [31:0]   tgt_rdata
);
  localparam int KW = (NKH > 1) ? $clog2(NKH) : 1;
  localparam int BW = AW - 2;
  localparam logic [1:0] RG_CTL = 2'd0, RG_WD = 2'd1, RG_MTX = 2'd2;

  logic [NKH-1:0] busy, dir, tmo_f, serr_f, mtx, hit;
  logic [3:0]  dev  [NKH];
  logic [15:0] radr [NKH];
  logic [31:0] wdat [NKH];
  logic [31:0] rdat [NKH];
  logic [TMO_W-1:0] tmo_lim, timer;
  logic active, gnt_vld;
  logic [KW-1:0] cur, last, gnt_idx;

  wire [BW-1:0] blk = cpu_addr[AW-1:2];
  wire [1:0] rg = cpu_addr[1:0];
  wire tmo_sel = (blk == '0) && (rg == RG_CTL);
  wire tmo_en = (tmo_lim != '0);
  wire done_ok = active && tgt_ack;
  wire done_to = active && !tgt_ack && tmo_en && (timer == tmo_lim - 1'b1);

  always_comb
    for (int k = 0; k < NKH; k++) hit[k] = (blk == BW'(k + 1));

  always_comb begin
    int j;
    gnt_vld = 1'b0;
    gnt_idx = last;
    for (int i = 1; i <= NKH; i++) begin
      j = int'(last) + i;
      if (j >= NKH) j = j - NKH;
      if (!gnt_vld && busy[j]) begin
        gnt_vld = 1'b1;
        gnt_idx = KW'(j);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active  <= 1'b0;
      cur     <= '0;
      last    <= KW'(NKH - 1);
      timer   <= '0;
      tmo_lim <= TMO_RST;
      busy    <= '0;
      dir     <= '0;
      tmo_f   <= '0;
      serr_f  <= '0;
      mtx     <= '0;
      for (int k = 0; k < NKH; k++) begin
        dev[k]  <= '0;
        radr[k] <= '0;
        wdat[k] <= '0;
        rdat[k] <= '0;
      end
    end else begin
      if (!active && gnt_vld) begin
        active <= 1'b1;
        cur    <= gnt_idx;
        last   <= gnt_idx;
        timer  <= '0;
      end else if (done_ok || done_to) begin
        active <= 1'b0;
      end else if (active) begin
        timer <= timer + 1'b1;
      end

      if (cpu_wr && tmo_sel) tmo_lim <= cpu_wdata[TMO_W-1:0];

      for (int k = 0; k < NKH; k++) begin
        if (cpu_wr && hit[k]) begin
          case (rg)
            RG_CTL: if (!busy[k]) begin
              dir[k]  <= cpu_wdata[24];
              dev[k]  <= cpu_wdata[23:20];
              radr[k] <= cpu_wdata[15:0];
              if (cpu_wdata[31]) begin
                busy[k]   <= 1'b1;
                tmo_f[k]  <= 1'b0;
                serr_f[k] <= 1'b0;
              end
            end
            RG_WD:  if (!busy[k]) wdat[k] <= cpu_wdata;
            RG_MTX: mtx[k] <= |cpu_wdata;
            default: ;
          endcase
        end else if (cpu_rd && hit[k] && rg == RG_MTX) begin
          mtx[k] <= 1'b1;
        end

        if (cur == KW'(k) && (done_ok || done_to)) begin
          busy[k] <= 1'b0;
          if (done_ok) begin
            serr_f[k] <= tgt_err;
            if (!dir[k]) rdat[k] <= tgt_rdata;
          end else begin
            tmo_f[k] <= 1'b1;
          end
        end
      end
    end
  end

  assign tgt_req   = active;
  assign tgt_we    = dir[cur];
  assign tgt_dev   = dev[cur];
  assign tgt_addr  = radr[cur];
  assign tgt_wdata = wdat[cur];

  always_comb begin
    cpu_rdata = '0;
    if (tmo_sel) cpu_rdata = 32'(tmo_lim);
    for (int k = 0; k < NKH; k++) begin
      if (hit[k]) begin
        case (rg)
          2'd0: cpu_rdata = {1'b0, tmo_f[k], serr_f[k], busy[k], 3'b0, dir[k],
                             dev[k], 4'b0, radr[k]};
          2'd1: cpu_rdata = wdat[k];
          2'd2: cpu_rdata = {31'b0, mtx[k]};
          default: cpu_rdata = rdat[k];
        endcase
      end
    end
  end

  // R3
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(tgt_req) && tgt_req |-> $stable(tgt_addr) && $stable(tgt_we) &&
    $stable(tgt_dev) && $stable(tgt_wdata));

  // R3
  busy_own_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tgt_req |-> busy[cur]);

  // R7
  timer_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tgt_req && tmo_en |-> timer < tmo_lim);

  // R8
  req_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tgt_req && tgt_ack |=> !tgt_req);

  // R5
  busy_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    |(busy & ~$past(busy)) |-> $past(cpu_wr));

  // R6
  serr_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    |(serr_f & ~$past(serr_f)) |-> $past(tgt_ack && tgt_err));
endmodule

// File: tb/kh_bus_bridge_tb_top.sv
`timescale 1ns/1ps
module kh_bus_bridge_tb_top;
  localparam int AW = 5;

  typedef struct {
    logic        we;
    logic [3:0]  dev;
    logic [15:0] addr;
    logic [31:0] wdata;
  } item_t;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cpu_wr = 1'b0, cpu_rd = 1'b0;
  logic [AW-1:0] cpu_addr = '0;
  logic [31:0] cpu_wdata = '0;
  logic [31:0] cpu_rdata;
  logic tgt_req, tgt_we;
  logic [3:0] tgt_dev;
  logic [15:0] tgt_addr;
  logic [31:0] tgt_wdata;
  logic tgt_ack = 1'b0, tgt_err = 1'b0;
  logic [31:0] tgt_rdata = '0;

  int n_chk = 0, n_fail = 0;
  int dly = 3, cnt = 0, run = 0, last_run = 0;
  bit err_mode = 1'b0;
  item_t exp_q[$];

  always #2 clk = ~clk;

  kh_bus_bridge dut_i (
    .clk(clk), .rst_n(rst_n), .cpu_wr(cpu_wr), .cpu_rd(cpu_rd),
    .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata),
    .tgt_req(tgt_req), .tgt_we(tgt_we), .tgt_dev(tgt_dev), .tgt_addr(tgt_addr),
    .tgt_wdata(tgt_wdata), .tgt_ack(tgt_ack), .tgt_err(tgt_err),
    .tgt_rdata(tgt_rdata)
  );

  function automatic logic [31:0] tgt_fn(logic [3:0] d, logic [15:0] a);
    return {8'h5A, 4'h0, d, a};
  endfunction

  function automatic logic [31:0] ctl_val(bit st, bit we, logic [3:0] d, logic [15:0] a);
    return {st, 6'b0, we, d, 4'b0, a};
  endfunction

  task automatic chk(bit ok, string req, string what, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // target model and scoreboard monitor
  always @(negedge clk) begin
    if (!tgt_req) begin
      if (run != 0) last_run = run;
      run = 0; cnt = 0; tgt_ack = 1'b0; tgt_err = 1'b0;
    end else begin
      run++; cnt++;
      if (cnt == dly) begin
        tgt_ack = 1'b1; tgt_err = err_mode; tgt_rdata = tgt_fn(tgt_dev, tgt_addr);
        if (exp_q.size() == 0) begin
          chk(1'b0, "R2", "unexpected transaction addr", 32'(tgt_addr), 32'hFFFF_FFFF);
        end else begin
          item_t e;
          e = exp_q.pop_front();
          chk(tgt_we == e.we && tgt_dev == e.dev && tgt_addr == e.addr &&
              tgt_wdata == e.wdata, "R2/R8", "transaction fields",
              {tgt_we, 3'b0, tgt_dev, tgt_addr, 8'h0}, {e.we, 3'b0, e.dev, e.addr, 8'h0});
          chk(tgt_wdata == e.wdata, "R2", "target write data", tgt_wdata, e.wdata);
        end
      end else begin
        tgt_ack = 1'b0; tgt_err = 1'b0;
      end
    end
  end

  task automatic cpu_write(logic [AW-1:0] a, logic [31:0] d);
    @(negedge clk);
    cpu_wr = 1'b1; cpu_addr = a; cpu_wdata = d;
    @(posedge clk); #1;
    cpu_wr = 1'b0;
  endtask

  task automatic cpu_read(logic [AW-1:0] a, output logic [31:0] d);
    @(negedge clk);
    cpu_rd = 1'b1; cpu_addr = a;
    #1 d = cpu_rdata;
    @(posedge clk); #1;
    cpu_rd = 1'b0;
  endtask

  function automatic logic [AW-1:0] kaddr(int k, int r);
    return AW'(4 * (k + 1) + r);
  endfunction

  task automatic exp_push(bit we, logic [3:0] d, logic [15:0] a, logic [31:0] wd);
    item_t e;
    e.we = we; e.dev = d; e.addr = a; e.wdata = wd;
    exp_q.push_back(e);
  endtask

  task automatic start_txn(int k, bit we, logic [3:0] d, logic [15:0] a, logic [31:0] wd);
    cpu_write(kaddr(k, 1), wd);
    cpu_write(kaddr(k, 0), ctl_val(1'b1, we, d, a));
  endtask

  task automatic wait_idle(int k);
    logic [31:0] v;
    for (int i = 0; i < 500; i++) begin
      cpu_read(kaddr(k, 0), v);
      if (!v[28]) break;
    end
  endtask

  initial begin
    #600000;
    n_fail++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [31:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    chk(tgt_req == 1'b0, "R1", "request after reset", 32'(tgt_req), 0);
    for (int k = 0; k < 4; k++) begin
      cpu_read(kaddr(k, 0), v);
      chk(v == 0, "R1", "control after reset", v, 0);
    end
    cpu_read(0, v);
    chk(v == 64, "R1", "timeout limit after reset", v, 64);

    // R2 R3 R4 write transaction
    dly = 3;
    exp_push(1'b1, 4'd3, 16'h1234, 32'hCAFE_F00D);
    start_txn(1, 1'b1, 4'd3, 16'h1234, 32'hCAFE_F00D);
    cpu_read(kaddr(1, 0), v);
    chk(v == (ctl_val(0, 1, 3, 16'h1234) | 32'h1000_0000), "R3", "busy during write", v,
        ctl_val(0, 1, 3, 16'h1234) | 32'h1000_0000);
    wait_idle(1);
    cpu_read(kaddr(1, 0), v);
    chk(v == ctl_val(0, 1, 3, 16'h1234), "R3", "control after write", v, ctl_val(0, 1, 3, 16'h1234));
    cpu_read(kaddr(1, 3), v);
    chk(v == 0, "R4", "read data untouched by write", v, 0);

    // R4 read transaction
    exp_push(1'b0, 4'd5, 16'h00AB, 32'h0);
    start_txn(2, 1'b0, 4'd5, 16'h00AB, 32'h0);
    wait_idle(2);
    cpu_read(kaddr(2, 3), v);
    chk(v == tgt_fn(4'd5, 16'h00AB), "R4", "captured read data", v, tgt_fn(4'd5, 16'h00AB));

    // R5 writes while busy ignored
    dly = 20;
    exp_push(1'b0, 4'd1, 16'h0011, 32'h1111_2222);
    start_txn(0, 1'b0, 4'd1, 16'h0011, 32'h1111_2222);
    start_txn(0, 1'b1, 4'd7, 16'h0022, 32'hDEAD_BEEF);
    cpu_read(kaddr(0, 0), v);
    chk(v == (ctl_val(0, 0, 1, 16'h0011) | 32'h1000_0000), "R5", "control kept while busy", v,
        ctl_val(0, 0, 1, 16'h0011) | 32'h1000_0000);
    cpu_read(kaddr(0, 1), v);
    chk(v == 32'h1111_2222, "R5", "write data kept while busy", v, 32'h1111_2222);
    wait_idle(0);
    repeat (4) @(negedge clk);
    chk(exp_q.size() == 0, "R5", "no extra transaction", exp_q.size(), 0);

    // R6 slave error sticky, R9 cleared by start
    dly = 2; err_mode = 1'b1;
    exp_push(1'b1, 4'd2, 16'h0400, 32'h0000_00FF);
    start_txn(3, 1'b1, 4'd2, 16'h0400, 32'h0000_00FF);
    wait_idle(3);
    err_mode = 1'b0;
    repeat (5) @(negedge clk);
    cpu_read(kaddr(3, 0), v);
    chk(v == (ctl_val(0, 1, 2, 16'h0400) | 32'h2000_0000), "R6", "slave error sticky", v,
        ctl_val(0, 1, 2, 16'h0400) | 32'h2000_0000);
    dly = 6;
    exp_push(1'b1, 4'd2, 16'h0401, 32'h0000_00FF);
    cpu_write(kaddr(3, 0), ctl_val(1, 1, 2, 16'h0401));
    cpu_read(kaddr(3, 0), v);
    chk(v == (ctl_val(0, 1, 2, 16'h0401) | 32'h1000_0000), "R9", "start clears slave error", v,
        ctl_val(0, 1, 2, 16'h0401) | 32'h1000_0000);
    wait_idle(3);

    // R7 timeout after exactly L cycles
    cpu_write(0, 32'd8);
    dly = 9;
    start_txn(0, 1'b1, 4'd2, 16'h0300, 32'h5555_AAAA);
    wait_idle(0);
    repeat (2) @(negedge clk);
    cpu_read(kaddr(0, 0), v);
    chk(v == (ctl_val(0, 1, 2, 16'h0300) | 32'h4000_0000), "R7", "timeout flag", v,
        ctl_val(0, 1, 2, 16'h0300) | 32'h4000_0000);
    chk(last_run == 8, "R7", "request length at timeout", last_run, 8);

    // R7 acknowledge in the last allowed cycle, R9 clears timeout flag
    dly = 8;
    exp_push(1'b1, 4'd2, 16'h0301, 32'h5555_AAAA);
    cpu_write(kaddr(0, 0), ctl_val(1, 1, 2, 16'h0301));
    cpu_read(kaddr(0, 0), v);
    chk(v[30] == 1'b0 && v[28] == 1'b1, "R9", "start clears timeout flag", v,
        ctl_val(0, 1, 2, 16'h0301) | 32'h1000_0000);
    wait_idle(0);
    cpu_read(kaddr(0, 0), v);
    chk(v == ctl_val(0, 1, 2, 16'h0301), "R7", "ack in last cycle wins", v, ctl_val(0, 1, 2, 16'h0301));
    chk(last_run == 8, "R7", "request length with late ack", last_run, 8);

    // R11 limit of zero disables timeout
    cpu_write(0, 32'd0);
    dly = 40;
    exp_push(1'b0, 4'd6, 16'hBEEF, 32'h0);
    start_txn(1, 1'b0, 4'd6, 16'hBEEF, 32'h0);
    wait_idle(1);
    cpu_read(kaddr(1, 0), v);
    chk(v == ctl_val(0, 0, 6, 16'hBEEF), "R11", "no timeout with zero limit", v, ctl_val(0, 0, 6, 16'hBEEF));
    cpu_read(kaddr(1, 3), v);
    chk(v == tgt_fn(4'd6, 16'hBEEF), "R11", "late read data", v, tgt_fn(4'd6, 16'hBEEF));

    // R8 round robin: kh2 served first, then 3, 0, 1
    cpu_write(0, 32'd64);
    dly = 12;
    exp_push(1'b1, 4'd2, 16'h2002, 32'h2222_2222);
    exp_push(1'b1, 4'd3, 16'h3003, 32'h3333_3333);
    exp_push(1'b1, 4'd0, 16'h0000, 32'h0000_0001);
    exp_push(1'b1, 4'd1, 16'h1001, 32'h1111_1111);
    start_txn(2, 1'b1, 4'd2, 16'h2002, 32'h2222_2222);
    start_txn(1, 1'b1, 4'd1, 16'h1001, 32'h1111_1111);
    start_txn(0, 1'b1, 4'd0, 16'h0000, 32'h0000_0001);
    start_txn(3, 1'b1, 4'd3, 16'h3003, 32'h3333_3333);
    for (int k = 0; k < 4; k++) wait_idle(k);
    repeat (4) @(negedge clk);
    chk(exp_q.size() == 0, "R8", "all round-robin transactions seen", exp_q.size(), 0);

    // R10 mutex
    cpu_read(kaddr(1, 2), v);
    chk(v == 0, "R10", "first mutex read", v, 0);
    cpu_read(kaddr(1, 2), v);
    chk(v == 1, "R10", "second mutex read", v, 1);
    cpu_read(kaddr(2, 2), v);
    chk(v == 0, "R10", "other keyhole mutex free", v, 0);
    cpu_write(kaddr(1, 2), 32'd0);
    cpu_read(kaddr(1, 2), v);
    chk(v == 0, "R10", "mutex after release", v, 0);

    repeat (4) @(negedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule